// File: doc/BRIEF.md
# Condition-Gated Execution Unit

This block sits beside an instruction pipeline and decides, one issued operation at a time, whether that operation may take effect. It keeps the four status flags in a register: negative, zero, carry and overflow. Every operation carries a 4-bit condition code, and the block tests that code against the stored flags. The result is an execute-enable that the rest of the pipeline uses to gate register writeback. The same enable, together with the operation's set-flags bit, decides whether the flag values offered by the datapath are captured.

A pass depends only on the flags as they stood before the current operation. A flag-setting operation therefore influences the operations after it, not itself. Decode, the arithmetic datapath and branch target work live elsewhere. This block only holds the flags and produces the gate.

Flag vectors on the ports use the bit order N = bit 3, Z = bit 2, C = bit 1, V = bit 0.

Top module: `cond_exec_unit`

## Requirements
- R1: While `rst_n` is low, `flags_q` is 4'b0000. The flags stay zero after reset is released until a flag write happens.
- R2: Code 4'b0000 passes when Z is 1, and code 4'b0001 passes when Z is 0.
- R3: Code 4'b0010 passes when C is 1 and 4'b0011 when C is 0. Code 4'b0100 passes when N is 1 and 4'b0101 when N is 0, so a zero result counts as non-negative. Code 4'b0110 passes when V is 1 and 4'b0111 when V is 0.
- R4: Code 4'b1000 passes when C is 1 and Z is 0. Code 4'b1001 passes when C is 0 or Z is 1.
- R5: Code 4'b1010 passes when N equals V. Code 4'b1011 passes when N differs from V.
- R6: Code 4'b1100 passes when Z is 0 and N equals V. Code 4'b1101 passes when Z is 1 or N differs from V.
- R7: Code 4'b1110 passes for every flag value. Code 4'b1111 never passes: `exec_en` stays low and the flags are unchanged, even with `op_setflags` high.
- R8: `exec_en` is high exactly when `op_valid` is high and `cond_pass` is high. `cond_pass` reflects the code on `op_cond` whether or not `op_valid` is high.
- R9: On a rising clock edge, `flags_q` takes `new_flags` when `exec_en` and `op_setflags` are both high. On every other edge it holds its value.
- R10: `cond_pass` is evaluated against `flags_q`, the flags registered before the current operation. The `new_flags` presented in the same cycle have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_valid | input | 1 | An operation is issued this cycle |
| op_cond | input | 4 | Condition code of the issued operation |
| op_setflags | input | 1 | The operation requests a flag update |
| new_flags | input | 4 | Flag values produced by the datapath {N,Z,C,V} |
| exec_en | output | 1 | Operation executes; gates writeback and flag update |
| cond_pass | output | 1 | Condition code holds for the current flags |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench sweeps every condition code against all sixteen flag states, with `op_valid` both high and low. A swapped pair polarity, a mistyped signed compare (such as GT without the Z term), or an NV code that slips through would each show up as a wrong `cond_pass` for some pattern. For flag writes, the bench offers the bitwise complement of the stored flags in the same cycle. A design that evaluated against the incoming flags would flip its pass result. A design that wrote flags without S, on a failed condition, or with `op_valid` low would change `flags_q` where it must hold. Reset is also applied again after the flags were loaded, to catch a register that never clears.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    CND_EQ = 4'b0000, CND_NE = 4'b0001,
    CND_CS = 4'b0010, CND_CC = 4'b0011,
    CND_MI = 4'b0100, CND_PL = 4'b0101,
    CND_VS = 4'b0110, CND_VC = 4'b0111,
    CND_HI = 4'b1000, CND_LS = 4'b1001,
    CND_GE = 4'b1010, CND_LT = 4'b1011,
    CND_GT = 4'b1100, CND_LE = 4'b1101,
    CND_AL = 4'b1110, CND_NV = 4'b1111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_exec_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  flags_t f;
  logic   base;
  logic   n_eq_v;

  assign f      = flags_t'(flags);
  assign n_eq_v = (f.n == f.v);

  // Codes come in pairs: the upper three bits pick a predicate,
  // the lowest bit inverts it. The last pair is always/never.
  always_comb begin
    unique case (cond[COND_W-1:1])
      3'd0:    base = f.z;
      3'd1:    base = f.c;
      3'd2:    base = f.n;
      3'd3:    base = f.v;
      3'd4:    base = f.c & ~f.z;
      3'd5:    base = n_eq_v;
      3'd6:    base = ~f.z & n_eq_v;
      default: base = 1'b1;
    endcase
  end

  assign pass = base ^ cond[0];
endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter int unsigned        W       = 4,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_next;
  end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
  import cond_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [COND_W-1:0] op_cond,
  input  logic              op_setflags,
  input  logic [FLAG_W-1:0] new_flags,
  output logic              exec_en,
  output logic              cond_pass,
  output logic [FLAG_W-1:0] flags_q
);
  logic flag_we;

  cond_eval u_eval (
    .cond  (op_cond),
    .flags (flags_q),
    .pass  (cond_pass)
  );

  assign exec_en = op_valid & cond_pass;
  assign flag_we = exec_en & op_setflags;

  flag_reg #(.W(FLAG_W), .RST_VAL('0)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_we),
    .d     (new_flags),
    .q     (flags_q)
  );

  p_nv_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cond == CND_NV) |-> !exec_en);

  p_al_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cond == CND_AL) |-> cond_pass);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !exec_en);

  p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_setflags) |=> (flags_q == $past(new_flags)));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && op_setflags) |=> $stable(flags_q));
endmodule

// File: tb/cond_exec_unit_tb_top.sv
module cond_exec_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_cond;
  logic       op_setflags;
  logic [3:0] new_flags;
  logic       exec_en;
  logic       cond_pass;
  logic [3:0] flags_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  cond_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cond(op_cond),
    .op_setflags(op_setflags), .new_flags(new_flags),
    .exec_en(exec_en), .cond_pass(cond_pass), .flags_q(flags_q)
  );

  function automatic bit model_pass(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c < 2)       return "R2";
    else if (c < 8)  return "R3";
    else if (c < 10) return "R4";
    else if (c < 12) return "R5";
    else if (c < 14) return "R6";
    else             return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Load flags with an always-true flag-setting operation.
  task automatic load_flags(input logic [3:0] f);
    op_valid = 1'b1; op_cond = 4'hE; op_setflags = 1'b1; new_flags = f;
    @(posedge clk); #1;
    op_valid = 1'b0; op_setflags = 1'b0;
    check("R9", "load via AL", flags_q, f);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_cond = 4'h0;
    op_setflags = 1'b0; new_flags = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "flags in reset", flags_q, 4'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "flags after release", flags_q, 4'h0);

    // Evaluation sweep: every code against every flag state.
    for (int f = 0; f < 16; f++) begin
      load_flags(4'(f));
      for (int c = 0; c < 16; c++) begin
        op_cond = 4'(c); op_setflags = 1'b0;
        op_valid = 1'b1; #1;
        check(req_of(4'(c)), "cond_pass", {3'b0, cond_pass},
              {3'b0, model_pass(4'(c), 4'(f))});
        check("R8", "exec_en valid", {3'b0, exec_en},
              {3'b0, model_pass(4'(c), 4'(f))});
        op_valid = 1'b0; #1;
        check("R8", "exec_en idle", {3'b0, exec_en}, 4'h0);
        check("R8", "cond_pass idle", {3'b0, cond_pass},
              {3'b0, model_pass(4'(c), 4'(f))});
      end
    end

    // Update sweep: offer the complement of the stored flags.
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        for (int s = 0; s < 2; s++) begin
          bit p;
          logic [3:0] exp;
          load_flags(4'(f));
          p = model_pass(4'(c), 4'(f));
          op_valid = 1'b1; op_cond = 4'(c); op_setflags = s[0];
          new_flags = ~4'(f); #1;
          check("R10", "pass uses old flags", {3'b0, cond_pass}, {3'b0, p});
          exp = (s[0] && p) ? ~4'(f) : 4'(f);
          @(posedge clk); #1;
          op_valid = 1'b0; op_setflags = 1'b0;
          check((c == 15) ? "R7" : "R9", "flags after op", flags_q, exp);
        end
      end
      // Not valid: no write even with S and an always code.
      op_valid = 1'b0; op_cond = 4'hE; op_setflags = 1'b1; new_flags = ~flags_q;
      begin
        logic [3:0] keep;
        keep = flags_q;
        @(posedge clk); #1;
        check("R9", "no write when idle", flags_q, keep);
      end
      op_setflags = 1'b0;
    end

    // Reset clears loaded flags.
    load_flags(4'hF);
    rst_n = 1'b0; #1;
    check("R1", "reset clears", flags_q, 4'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "zero after re-release", flags_q, 4'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule